// File: doc/BRIEF.md
# Two-Stage Pipelined Multiply-Accumulator

This block keeps a running signed sum. On every clock it takes two signed operands, forms their product, and adds that product to an internal state register. The state is driven straight onto the output port. Both operands are first captured in input registers. After that capture, the datapath comes in one of two builds, picked by a parameter.

In the reference build, the product goes straight into the adder in the same cycle. In the pipelined build, an intermediate register holds the product between the multiplier and the adder. This splits the long multiply-then-add path into two shorter stages.

The product never depends on the state, so the only feedback loop is the state register around the adder. As a result, the pipelined build needs no stalls or bubbles. Its output stream is the reference stream with one extra leading zero. All arithmetic is two's complement, and the state wraps modulo 2^ACC_W.

Top module: `mac_pipe2`

## Requirements
- R1: A synchronous reset clears every register: the operand registers, the product register and the state. `acc_out` reads 0 on the edge after reset is sampled. Operand values that were held at the inputs during reset never reach the sum.
- R2: Reference build (PIPELINED=0): count clock edges after reset is released from 0, and call the operands applied before edge i pair i. After edge k, `acc_out` equals the sum of the products of pairs 0..k-1, reduced modulo 2^ACC_W. After edge 0 it is 0.
- R3: Pipelined build (PIPELINED=1): after edge k, `acc_out` equals the sum of the products of pairs 0..k-2, reduced modulo 2^ACC_W. This is the reference output of edge k-1, so the outputs after edges 0 and 1 are both 0.
- R4: Operands are W-bit two's-complement values, and each product is the full signed 2W-bit product, sign-extended to ACC_W bits. With W=4, (-8)*(-8) adds +64 and (-8)*7 adds -56. The product -56 reads 0xC8 when ACC_W=8.
- R5: The state wraps modulo 2^ACC_W with no saturation. With W=4 and ACC_W=8, four additions of +64 starting from 0 return `acc_out` to 0.
- R6: A pair in which either operand is zero leaves `acc_out` unchanged. The reference build shows this at the second edge after that pair is applied, and the pipelined build at the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | W | First signed operand |
| op_b | input | W | Second signed operand |
| acc_out | output | ACC_W | Current value of the state register |

## Verification
A fault in the operand or product registers shows at the output within two or three edges. Once visible, it persists: every later value is offset by the stale or missing term, and the sum never corrects itself. A product register that survives reset shows up as a non-zero output on the first edges after release, where both builds must still read zero.

The bench sweeps every signed operand pair of a 4-bit configuration through both builds side by side. It compares each output with sums it computes itself. This also tests the one-cycle offset between the two builds edge by edge, and it reaches the wrap point several times.

// File: rtl/mac_pipe2_pkg.sv
package mac_pipe2_pkg;

   // Datapath build selector
   typedef enum logic {
      MAC_BUILD_COMB = 1'b0,
      MAC_BUILD_PIPE = 1'b1
   } mac_build_e;

   // Width of a full signed product of two w-bit operands
   function automatic int prod_width(input int w);
      return 2 * w;
   endfunction

   // Edges from operand capture to a visible change on the output
   function automatic int result_latency(input int pipelined);
      return (pipelined != 0) ? 3 : 2;
   endfunction

endpackage

// File: rtl/mac_opnd_reg.sv
module mac_opnd_reg #(
   parameter int W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] a_d,
   input  logic signed [W-1:0] b_d,
   output logic signed [W-1:0] a_q,
   output logic signed [W-1:0] b_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         a_q <= a_d;
         b_q <= b_d;
      end
   end

endmodule

// File: rtl/mac_mult.sv
module mac_mult
   import mac_pipe2_pkg::*;
#(
   parameter int W     = 8,
   parameter int ACC_W = 32
) (
   input  logic signed [W-1:0]     a,
   input  logic signed [W-1:0]     b,
   output logic        [ACC_W-1:0] p
);

   localparam int PW = prod_width(W);

   logic signed [PW-1:0]    full;
   logic signed [ACC_W-1:0] ext;

   assign full = PW'(a) * PW'(b);
   assign ext  = ACC_W'(full);
   assign p    = ext;

endmodule

// File: rtl/mac_prod_reg.sv
module mac_prod_reg #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] p_d,
   output logic [ACC_W-1:0] p_q
);

   always_ff @(posedge clk) begin
      if (rst) p_q <= '0;
      else     p_q <= p_d;
   end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] addend,
   output logic [ACC_W-1:0] state
);

   always_ff @(posedge clk) begin
      if (rst) state <= '0;
      else     state <= state + addend;
   end

endmodule

// File: rtl/mac_pipe2.sv
module mac_pipe2
   import mac_pipe2_pkg::*;
#(
   parameter int W         = 8,
   parameter int ACC_W     = 32,
   parameter int PIPELINED = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] op_a,
   input  logic signed [W-1:0] op_b,
   output logic [ACC_W-1:0]    acc_out
);

   localparam mac_build_e BUILD = (PIPELINED != 0) ? MAC_BUILD_PIPE : MAC_BUILD_COMB;

   // Elaboration-time parameter checks
   if (W < 2) begin : g_bad_w
      $error("mac_pipe2: W must be at least 2");
   end
   if (ACC_W < prod_width(W)) begin : g_bad_accw
      $error("mac_pipe2: ACC_W must hold a full product (>= 2*W)");
   end
   if (PIPELINED != 0 && PIPELINED != 1) begin : g_bad_mode
      $error("mac_pipe2: PIPELINED must be 0 or 1");
   end

   logic signed [W-1:0] a_q, b_q;
   logic [ACC_W-1:0]    prod_c;
   logic [ACC_W-1:0]    addend;

   mac_opnd_reg #(.W(W)) u_opnd (
      .clk (clk),
      .rst (rst),
      .a_d (op_a),
      .b_d (op_b),
      .a_q (a_q),
      .b_q (b_q)
   );

   mac_mult #(.W(W), .ACC_W(ACC_W)) u_mult (
      .a (a_q),
      .b (b_q),
      .p (prod_c)
   );

   if (BUILD == MAC_BUILD_PIPE) begin : g_pipe
      mac_prod_reg #(.ACC_W(ACC_W)) u_prod (
         .clk (clk),
         .rst (rst),
         .p_d (prod_c),
         .p_q (addend)
      );
   end else begin : g_comb
      assign addend = prod_c;
   end

   mac_accum #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .addend (addend),
      .state  (acc_out)
   );

endmodule

// File: rtl/mac_pipe2_chk.sv
module mac_pipe2_chk #(
   parameter int W         = 8,
   parameter int ACC_W     = 32,
   parameter int PIPELINED = 1
) (
   input logic                clk,
   input logic                rst,
   input logic signed [W-1:0] a_in,
   input logic signed [W-1:0] b_in,
   input logic [ACC_W-1:0]    acc_out
);

   function automatic logic [ACC_W-1:0] term(input logic signed [W-1:0] x,
                                              input logic signed [W-1:0] y);
      logic signed [2*W-1:0]  f;
      logic signed [ACC_W-1:0] e;
      f = (2*W)'(x) * (2*W)'(y);
      e = ACC_W'(f);
      return e;
   endfunction

   // R1
   rst_clear_chk: assert property (@(posedge clk) rst |=> acc_out == '0);

   if (PIPELINED != 0) begin : g_pipe_chk
      // R3
      pipe_accum_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$past(rst, 2) && !$past(rst, 3)) |->
         acc_out == $past(acc_out) + term($past(a_in, 3), $past(b_in, 3)));
      // R6
      pipe_hold_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && ($past(a_in, 3) == '0 || $past(b_in, 3) == '0)) |->
         acc_out == $past(acc_out));
   end else begin : g_comb_chk
      // R2
      ref_accum_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$past(rst, 2)) |->
         acc_out == $past(acc_out) + term($past(a_in, 2), $past(b_in, 2)));
      // R6
      ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && ($past(a_in, 2) == '0 || $past(b_in, 2) == '0)) |->
         acc_out == $past(acc_out));
   end

endmodule

bind mac_pipe2 mac_pipe2_chk #(
   .W(W), .ACC_W(ACC_W), .PIPELINED(PIPELINED)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .a_in    (op_a),
   .b_in    (op_b),
   .acc_out (acc_out)
);

// File: tb/mac_pipe2_tb.sv
`timescale 1ns/1ps
module mac_pipe2_tb;

   localparam int W     = 4;
   localparam int ACC_W = 8;
   localparam int LO    = -(1 << (W-1));
   localparam int SPAN  = 1 << W;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic signed [W-1:0] op_a = '0;
   logic signed [W-1:0] op_b = '0;
   logic [ACC_W-1:0]    acc_pipe, acc_ref;

   int total = 0;
   int bad   = 0;
   int idx   = 0;
   int cum [0:1023];
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   mac_pipe2 #(.W(W), .ACC_W(ACC_W), .PIPELINED(1)) u_dut (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .acc_out(acc_pipe));

   mac_pipe2 #(.W(W), .ACC_W(ACC_W), .PIPELINED(0)) u_ref (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .acc_out(acc_ref));

   task automatic chk(input string tag, input logic [ACC_W-1:0] act,
                      input logic [ACC_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s step=%0d actual=%0h expected=%0h", tag, idx, act, exp);
      end
   endtask

   // Hold reset for two edges with the given operands at the inputs (R1)
   task automatic restart(input int ha, input int hb);
      @(negedge clk);
      rst  = 1'b1;
      op_a = W'(ha);
      op_b = W'(hb);
      repeat (2) @(posedge clk);
      #1;
      chk("R1 pipelined after reset", acc_pipe, '0);
      chk("R1 reference after reset", acc_ref, '0);
      idx = 0;
   endtask

   // Apply pair idx before edge idx; ref = sum 0..idx-1 (R2), pipe = sum 0..idx-2 (R3)
   task automatic step(input int a, input int b, input string tref, input string tpipe);
      int er, ep;
      @(negedge clk);
      rst  = 1'b0;
      op_a = W'(a);
      op_b = W'(b);
      cum[idx] = ((idx > 0) ? cum[idx-1] : 0) + a * b;
      er = (idx >= 1) ? cum[idx-1] : 0;
      ep = (idx >= 2) ? cum[idx-2] : 0;
      @(posedge clk);
      #1;
      chk(tref,  acc_ref,  ACC_W'(er));
      chk(tpipe, acc_pipe, ACC_W'(ep));
      idx++;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog R2 run hung actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: clean reset
      restart(0, 0);

      // R2 R3 R4 R5: every signed operand pair, sums wrap repeatedly
      for (int i = 0; i < SPAN * SPAN; i++)
         step(LO + i / SPAN, LO + i % SPAN, "R2 sweep reference", "R3 sweep pipelined");
      step(0, 0, "R2 drain", "R3 drain");
      step(0, 0, "R2 drain", "R3 drain");

      // R4: signed extremes, -8*-8 = +64 and -8*7 = -56 (0xC8)
      restart(0, 0);
      step(-8, -8, "R4 ref", "R4 pipe");
      step(0, 0, "R4 ref +64", "R4 pipe");
      step(0, 0, "R4 ref", "R4 pipe +64");
      restart(0, 0);
      step(-8, 7, "R4 ref", "R4 pipe");
      step(0, 0, "R4 ref 0xC8", "R4 pipe");
      step(0, 0, "R4 ref", "R4 pipe 0xC8");

      // R5: four times +64 wraps back to zero
      restart(0, 0);
      for (int i = 0; i < 4; i++) step(-8, -8, "R5 ref", "R5 pipe");
      step(0, 0, "R5 ref wrap", "R5 pipe");
      step(0, 0, "R5 ref", "R5 pipe wrap");

      // R6: zero operands hold the sum
      restart(0, 0);
      step(3, 5, "R6 ref", "R6 pipe");
      step(0, 6, "R6 ref", "R6 pipe");
      step(-2, 0, "R6 ref", "R6 pipe");
      step(0, 0, "R6 ref", "R6 pipe");
      step(7, -1, "R6 ref", "R6 pipe");
      step(0, -8, "R6 ref", "R6 pipe");
      step(0, 0, "R6 ref", "R6 pipe");
      step(0, 0, "R6 ref", "R6 pipe");

      // R1: reset mid-run with a large pair held at the inputs
      for (int i = 0; i < 3; i++) step(7, 7, "R2 pre-reset", "R3 pre-reset");
      restart(7, 7);
      for (int i = 0; i < 4; i++) step(0, 0, "R1 ref no stale operand", "R1 pipe no stale product");
      step(2, 3, "R1 ref resume", "R1 pipe resume");
      step(0, 0, "R1 ref resume", "R1 pipe resume");
      step(0, 0, "R1 ref resume", "R1 pipe resume");

      finish_run();
   end

endmodule